// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block chooses which local interrupt a hart should take next. It receives the pending and enable vectors, a per-bit delegation mask that says whether each interrupt is handled at supervisor level or at machine level, the current privilege level, and the global enable bits for the machine and supervisor levels. It reports whether any interrupt may be taken and, if so, the index of that interrupt.

Each interrupt is a candidate only when it is both pending and enabled. Each candidate is then gated by the global enable of its target level. That global enable depends on the current privilege: running below the target level always allows the interrupt, running at the target level allows it only when that level's global enable bit is set, and running above the target level blocks it. Among the candidates that pass, the lowest-numbered one wins. A parameter places an optional register on the valid flag and the index, which gives the result one cycle of latency.

Top module: `irq_prio_sel`

## Requirements
- R1: Bit i can be reported only when both pend_i[i] and en_i[i] are 1. A pending bit whose enable is 0 is never selected.
- R2: A candidate with deleg_i[i]=0 targets machine level. It passes when priv_i is 0, 1 or 2, or when priv_i is 3 and m_gie_i is 1.
- R3: A candidate with deleg_i[i]=1 targets supervisor level. It passes when priv_i is 0 or 2, or when priv_i is 1 and s_gie_i is 1. It never passes when priv_i is 3.
- R4: When one or more candidates pass, valid_o is 1 and idx_o is the lowest bit number among them.
- R5: When no candidate passes, valid_o is 0 and idx_o is 0.
- R6: The privilege encoding is user=0, supervisor=1, machine=3. The code 2 gives the same result as user.
- R7: With REG_OUT=1 (the default), valid_o and idx_o show the result for the inputs of the previous clock edge. While rst_ni is low, both outputs are 0.
- R8: m_gie_i has no effect when priv_i is below 3. s_gie_i has no effect when priv_i is 0, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 16 | Pending interrupt vector |
| en_i | input | 16 | Per-interrupt enable vector |
| deleg_i | input | 16 | Per-interrupt delegation to supervisor level (1 = supervisor) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine, 2 as user |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| valid_o | output | 1 | An interrupt may be taken |
| idx_o | output | 4 | Index of the selected interrupt, 0 when valid_o is 0 |

## Verification
The assertions check on every cycle that a reported index is pending and enabled, that a supervisor-targeted index is never reported in machine mode, that machine mode with its global enable cleared reports no machine-targeted interrupt, that an empty candidate set gives an idle output with a zero index, and that an enabled machine-targeted bit 0 wins whenever privilege is below machine. The lowest-index ordering across arbitrary masks, the equivalence of privilege code 2 with user mode, and the insensitivity to a global enable bit that does not apply can only be shown by the bench, which compares each result against a reference model over directed corners and random vectors.

// File: rtl/irq_prio_sel_pkg.sv
package irq_prio_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Code 2 folds onto user level
  function automatic priv_e fold_priv(input logic [1:0] raw);
    return (raw == 2'd2) ? PRIV_USER : priv_e'(raw);
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_prio_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_gie_i,
  input  logic       s_gie_i,
  output logic       m_open_o,
  output logic       s_open_o
);

  priv_e lvl;

  always_comb begin
    lvl      = fold_priv(priv_i);
    m_open_o = 1'b0;
    s_open_o = 1'b0;
    unique case (lvl)
      PRIV_USER: begin
        m_open_o = 1'b1;
        s_open_o = 1'b1;
      end
      PRIV_SUPV: begin
        m_open_o = 1'b1;
        s_open_o = s_gie_i;
      end
      PRIV_MACH: begin
        m_open_o = m_gie_i;
        s_open_o = 1'b0;
      end
      default: begin
        m_open_o = 1'b1;
        s_open_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/irq_cand_mask.sv
module irq_cand_mask #(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic               m_open_i,
  input  logic               s_open_i,
  output logic [NUM_IRQ-1:0] surv_o
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic cand;
    logic lvl_open;
    assign cand      = pend_i[g] & en_i[g];
    assign lvl_open  = deleg_i[g] ? s_open_i : m_open_i;
    assign surv_o[g] = cand & lvl_open;
  end

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  // Scan from the top so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NUM_IRQ = 16,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic               m_open;
  logic               s_open;
  logic [NUM_IRQ-1:0] surv;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;

  irq_level_gate u_gate (
    .priv_i   (priv_i),
    .m_gie_i  (m_gie_i),
    .s_gie_i  (s_gie_i),
    .m_open_o (m_open),
    .s_open_o (s_open)
  );

  irq_cand_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .deleg_i  (deleg_i),
    .m_open_i (m_open),
    .s_open_i (s_open),
    .surv_o   (surv)
  );

  irq_low_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req_i (surv),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  if (REG_OUT) begin : g_reg
    logic             valid_q;
    logic [IDX_W-1:0] idx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        valid_q <= pick_any;
        idx_q   <= pick_idx;
      end
    end
    assign valid_o = valid_q;
    assign idx_o   = idx_q;
  end else begin : g_comb
    assign valid_o = pick_any;
    assign idx_o   = pick_idx;
  end

endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int unsigned NUM_IRQ = 16,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic               valid_o,
  input logic [IDX_W-1:0]   idx_o
);

  logic [NUM_IRQ-1:0] r_pend, r_en, r_deleg;
  logic [1:0]         r_priv;
  logic               r_mg;
  logic               live;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_pend  <= '0;
        r_en    <= '0;
        r_deleg <= '0;
        r_priv  <= '0;
        r_mg    <= 1'b0;
        live    <= 1'b0;
      end else begin
        r_pend  <= pend_i;
        r_en    <= en_i;
        r_deleg <= deleg_i;
        r_priv  <= priv_i;
        r_mg    <= m_gie_i;
        live    <= 1'b1;
      end
    end
  end else begin : g_now
    assign r_pend  = pend_i;
    assign r_en    = en_i;
    assign r_deleg = deleg_i;
    assign r_priv  = priv_i;
    assign r_mg    = m_gie_i;
    assign live    = 1'b1;
  end

  logic [NUM_IRQ-1:0] r_cand;
  assign r_cand = r_pend & r_en;

  p_pick_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && valid_o |-> r_cand[idx_o]);

  p_m_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && r_priv == 2'd3 && !r_mg && valid_o |-> r_deleg[idx_o]);

  p_s_blocked_in_m_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && r_priv == 2'd3 && valid_o |-> !r_deleg[idx_o]);

  p_bit0_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && r_cand[0] && !r_deleg[0] && r_priv != 2'd3 |-> valid_o && idx_o == '0);

  p_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && r_cand == '0 |-> !valid_o);

  p_idle_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> idx_o == '0);

  if (REG_OUT) begin : g_rst_chk
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        p_reset_clear_r7: assert (!valid_o && idx_o == '0);
      end
    end
  end

endmodule

bind irq_prio_sel irq_prio_sel_chk #(.NUM_IRQ(NUM_IRQ), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/irq_prio_sel_test.sv
module irq_prio_sel_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pend_i = '0;
  logic [15:0] en_i = '0;
  logic [15:0] deleg_i = '0;
  logic [1:0]  priv_i = '0;
  logic        m_gie_i = 1'b0;
  logic        s_gie_i = 1'b0;
  logic        valid_o;
  logic [3:0]  idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_prio_sel uut (
    .clk_i, .rst_ni, .pend_i, .en_i, .deleg_i,
    .priv_i, .m_gie_i, .s_gie_i, .valid_o, .idx_o
  );

  function automatic void ref_pick(input logic [15:0] p, input logic [15:0] e,
                                   input logic [15:0] d, input logic [1:0] pr,
                                   input logic mg, input logic sg,
                                   output logic v, output logic [3:0] ix);
    logic m_on, s_on;
    logic [15:0] ok;
    m_on = (pr != 2'd3) || mg;
    s_on = (pr == 2'd0) || (pr == 2'd2) || (pr == 2'd1 && sg);
    ok = p & e & ((~d & {16{m_on}}) | (d & {16{s_on}}));
    v = 1'b0;
    ix = '0;
    for (int i = 0; i < 16; i++) begin
      if (ok[i] && !v) begin
        v = 1'b1;
        ix = 4'(i);
      end
    end
  endfunction

  task automatic check_out(input string tag, input logic ev, input logic [3:0] eix);
    checks++;
    if (valid_o !== ev || idx_o !== eix) begin
      errors++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, valid_o, idx_o, ev, eix);
    end
  endtask

  // Drive just after a falling edge; result registered at next rise, sampled at next fall
  task automatic apply(input string tag, input logic [15:0] p, input logic [15:0] e,
                       input logic [15:0] d, input logic [1:0] pr,
                       input logic mg, input logic sg);
    logic ev;
    logic [3:0] eix;
    pend_i = p; en_i = e; deleg_i = d; priv_i = pr; m_gie_i = mg; s_gie_i = sg;
    ref_pick(p, e, d, pr, mg, sg, ev, eix);
    @(negedge clk_i);
    check_out(tag, ev, eix);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R7: reset state, with inputs that would otherwise select bit 2
    pend_i = 16'h0004; en_i = 16'hFFFF; priv_i = 2'd0;
    repeat (3) @(negedge clk_i);
    check_out("R7 reset", 1'b0, 4'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    apply("R5 all zero",            16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1, 1);
    apply("R1 pending not enabled", 16'h00F0, 16'hFF0F, 16'h0000, 2'd0, 1, 1);
    apply("R1 enable picks upper",  16'h00F0, 16'h0080, 16'h0000, 2'd1, 0, 0);
    apply("R2 mach closed",         16'hFFFF, 16'hFFFF, 16'h0000, 2'd3, 0, 1);
    apply("R2 mach open",           16'h0A00, 16'hFFFF, 16'h0000, 2'd3, 1, 0);
    apply("R2 below mach",          16'h0100, 16'hFFFF, 16'h0000, 2'd1, 0, 0);
    apply("R3 supv closed",         16'h0022, 16'hFFFF, 16'h0022, 2'd1, 1, 0);
    apply("R3 supv open",           16'h0022, 16'hFFFF, 16'h0022, 2'd1, 1, 1);
    apply("R3 blocked in mach",     16'h0003, 16'hFFFF, 16'h0001, 2'd3, 1, 1);
    apply("R3 user takes supv",     16'h0040, 16'hFFFF, 16'h0040, 2'd0, 0, 0);
    apply("R4 bit15 only",          16'h8000, 16'hFFFF, 16'h0000, 2'd0, 0, 0);
    apply("R4 bits 0 and 15",       16'h8001, 16'hFFFF, 16'h0000, 2'd0, 0, 0);
    apply("R4 lower supv masked",   16'h0C00, 16'hFFFF, 16'h0400, 2'd1, 1, 0);
    apply("R6 code2 as user",       16'h0030, 16'hFFFF, 16'h0010, 2'd2, 0, 0);
    apply("R6 code2 supv open",     16'h0008, 16'hFFFF, 16'h0008, 2'd2, 0, 0);
    apply("R8 m_gie ignored in S",  16'h0200, 16'hFFFF, 16'h0000, 2'd1, 0, 1);
    apply("R8 s_gie ignored in U",  16'h0004, 16'hFFFF, 16'h0004, 2'd0, 1, 0);
    apply("R8 s_gie ignored in M",  16'h0004, 16'hFFFF, 16'h0004, 2'd3, 1, 1);
    apply("R5 no survivor idx 0",   16'h8000, 16'hFFFF, 16'h8000, 2'd3, 1, 1);

    // R7: one-cycle latency across back-to-back changes
    apply("R7 seq a",               16'h0010, 16'hFFFF, 16'h0000, 2'd0, 0, 0);
    apply("R7 seq b",               16'h0002, 16'hFFFF, 16'h0000, 2'd0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] p, e, d;
      p = 16'($urandom);
      e = 16'($urandom) | 16'($urandom);
      d = 16'($urandom);
      apply("R4 random", p, e, d, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    // R7: reset clears a live result
    pend_i = 16'h0001; en_i = 16'h0001; deleg_i = '0; priv_i = 2'd0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_out("R7 async clear", 1'b0, 4'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule